// File: doc/BRIEF.md
# Four-State Sequence Machine with Selectable State Code

This block is a synchronous finite state machine. It has four abstract states, named A, B, C and D, a one-bit input `x` and a one-bit output `z`. Each rising clock edge moves the machine to its next state according to the current state and `x`. The output `z` is high only while the machine sits in state D. The raw state register is also driven out on its own port, so the state code can be observed.

A compile-time parameter selects one of two binary state codes. One code places states that share successors, or that are successors of the same state, at codes differing in one bit. The other code is a plain assignment with no such aim. Both builds give the same `z` sequence for any stimulus. They differ only in the bits on `state_code`.

A synchronous active-high reset returns the machine to state A under either code. Any code that decodes to no known state is sent to A on the next edge.

Top module: `fsm4_sel_enc`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is A, `state_code` becomes 2'b00 and `z` becomes 0, whatever `x` is and whichever code is built.
- R2: With `x`=0 at a rising edge the machine moves A to C, B to C, C to B and D to A.
- R3: With `x`=1 at a rising edge the machine moves A to D, B to A, C to D and D to B.
- R4: `z` is 1 exactly while the current state is D, whatever `x` is. `z` is registered together with the state, so it changes on the same edge as the state.
- R5: When `OPT_CODE`=1, `state_code` shows A=00, B=01, C=10, D=11.
- R6: When `OPT_CODE`=0, `state_code` shows A=00, B=01, C=11, D=10.
- R7: For the same reset and input sequence, builds with `OPT_CODE`=1 and `OPT_CODE`=0 produce the same `z` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to state A |
| x | input | 1 | Machine input sampled on each rising edge |
| z | output | 1 | Registered output, high in state D |
| state_code | output | 2 | Raw state register in the selected code |

## Verification
The clocked assertions assume that `x` and `rst` are stable and known at every rising edge after the first reset. They also assume that `rst` is high on the first edges, so the register never holds an unknown code. The bench drives both inputs on the falling edge from a seeded random source and asserts reset for the first cycles. Later resets come from random draws and directed steps, so every one of them falls inside these assumptions. Two builds, one for each code, run side by side on the same stimulus.

// File: rtl/fsm4_pkg.sv
package fsm4_pkg;

  localparam int CODE_W = 2;

  // Abstract state names; the physical code is chosen elsewhere.
  typedef enum logic [1:0] {
    ST_A = 2'd0,
    ST_B = 2'd1,
    ST_C = 2'd2,
    ST_D = 2'd3
  } st_e;

endpackage

// File: rtl/fsm4_next.sv
module fsm4_next
  import fsm4_pkg::*;
(
  input  st_e  cur_st,
  input  logic x,
  output st_e  nxt_st,
  output logic z_nxt
);

  always_comb begin
    unique case (cur_st)
      ST_A:    nxt_st = x ? ST_D : ST_C;
      ST_B:    nxt_st = x ? ST_A : ST_C;
      ST_C:    nxt_st = x ? ST_D : ST_B;
      ST_D:    nxt_st = x ? ST_B : ST_A;
      default: nxt_st = ST_A;
    endcase
  end

  // Output follows the state entered at this edge.
  assign z_nxt = (nxt_st == ST_D);

endmodule

// File: rtl/fsm4_codec.sv
module fsm4_codec
  import fsm4_pkg::*;
#(
  parameter bit OPT_CODE = 1'b1
) (
  input  st_e               enc_in,
  output logic [CODE_W-1:0] enc_out,
  input  logic [CODE_W-1:0] dec_in,
  output st_e               dec_out
);

  generate
    if (OPT_CODE) begin : g_adjacent
      // Shared-successor states sit one bit apart.
      always_comb begin
        unique case (enc_in)
          ST_A:    enc_out = 2'b00;
          ST_B:    enc_out = 2'b01;
          ST_C:    enc_out = 2'b10;
          ST_D:    enc_out = 2'b11;
          default: enc_out = 2'b00;
        endcase
      end
      always_comb begin
        case (dec_in)
          2'b00:   dec_out = ST_A;
          2'b01:   dec_out = ST_B;
          2'b10:   dec_out = ST_C;
          2'b11:   dec_out = ST_D;
          default: dec_out = ST_A;
        endcase
      end
    end else begin : g_plain
      always_comb begin
        unique case (enc_in)
          ST_A:    enc_out = 2'b00;
          ST_B:    enc_out = 2'b01;
          ST_C:    enc_out = 2'b11;
          ST_D:    enc_out = 2'b10;
          default: enc_out = 2'b00;
        endcase
      end
      always_comb begin
        case (dec_in)
          2'b00:   dec_out = ST_A;
          2'b01:   dec_out = ST_B;
          2'b11:   dec_out = ST_C;
          2'b10:   dec_out = ST_D;
          default: dec_out = ST_A;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/fsm4_sel_enc.sv
module fsm4_sel_enc
  import fsm4_pkg::*;
#(
  parameter bit OPT_CODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x,
  output logic              z,
  output logic [CODE_W-1:0] state_code
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  logic [CODE_W-1:0] code_rst;
  logic              z_q;
  logic              z_nxt;
  st_e               cur_st;
  st_e               nxt_st;

  fsm4_codec #(.OPT_CODE(OPT_CODE)) u_codec (
    .enc_in  (nxt_st),
    .enc_out (code_nxt),
    .dec_in  (code_q),
    .dec_out (cur_st)
  );

  fsm4_next u_next (
    .cur_st (cur_st),
    .x      (x),
    .nxt_st (nxt_st),
    .z_nxt  (z_nxt)
  );

  // State A is 00 in both codes.
  assign code_rst = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= code_rst;
      z_q    <= 1'b0;
    end else begin
      code_q <= code_nxt;
      z_q    <= z_nxt;
    end
  end

  assign z          = z_q;
  assign state_code = code_q;

  AST_CLR_TO_A: assert property (@(posedge clk)
    rst |=> (state_code == 2'b00 && !z)); // R1

  AST_D_X0_TO_A: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_D && !x) |=> (cur_st == ST_A)); // R2

  AST_B_X1_TO_A: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_B && x) |=> (cur_st == ST_A)); // R3

  AST_Z_IN_D: assert property (@(posedge clk) disable iff (rst)
    z == (cur_st == ST_D)); // R4

  AST_C_X1_TO_D: assert property (@(posedge clk) disable iff (rst)
    (cur_st == ST_C && x) |=> (z && cur_st == ST_D)); // R3

endmodule

// File: tb/tb_fsm4_sel_enc.sv
module tb_fsm4_sel_enc;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z_opt, z_arb;
  logic [1:0] sc_opt, sc_arb;

  int n_chk  = 0;
  int n_fail = 0;
  int mdl    = 0;   // 0=A 1=B 2=C 3=D
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fsm4_sel_enc #(.OPT_CODE(1'b1)) dut (
    .clk(clk), .rst(rst), .x(x), .z(z_opt), .state_code(sc_opt));

  fsm4_sel_enc #(.OPT_CODE(1'b0)) dut_arb (
    .clk(clk), .rst(rst), .x(x), .z(z_arb), .state_code(sc_arb));

  function automatic int ref_next(int s, logic xi);
    case (s)
      0: return xi ? 3 : 2;
      1: return xi ? 0 : 2;
      2: return xi ? 3 : 1;
      default: return xi ? 1 : 0;
    endcase
  endfunction

  function automatic logic [1:0] opt_code(int s);
    case (s)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] arb_code(int s);
    case (s)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic ez;
    ez = (mdl == 3);
    check(z_opt == ez, {tag, " R4 z opt"}, int'(z_opt), int'(ez));
    check(z_arb == ez, {tag, " R4 z arb"}, int'(z_arb), int'(ez));
    check(z_opt == z_arb, {tag, " R7 z match"}, int'(z_arb), int'(z_opt));
    check(sc_opt == opt_code(mdl), {tag, " R5 opt code"}, int'(sc_opt), int'(opt_code(mdl)));
    check(sc_arb == arb_code(mdl), {tag, " R6 arb code"}, int'(sc_arb), int'(arb_code(mdl)));
  endtask

  // Drive on the falling edge, update the model at the rising edge, sample 2 ns later.
  task automatic step(logic xi, logic ri, string tag);
    @(negedge clk);
    x   = xi;
    rst = ri;
    @(posedge clk);
    mdl = ri ? 0 : ref_next(mdl, xi);
    #2;
    check_all(tag);
  endtask

  task automatic go_to(int s);
    step(1'b0, 1'b1, "R1 clr");
    case (s)
      1: begin step(1'b0, 1'b0, "R2 A-C"); step(1'b0, 1'b0, "R2 C-B"); end
      2: step(1'b0, 1'b0, "R2 A-C");
      3: step(1'b1, 1'b0, "R3 A-D");
      default: ;
    endcase
  endtask

  initial begin
    void'($urandom(32'h5EED_0F5A));
    step(1'b0, 1'b1, "R1 reset");
    step(1'b1, 1'b1, "R1 reset x1");
    // Every state with each input value.
    for (int s = 0; s < 4; s++) begin
      for (int xv = 0; xv < 2; xv++) begin
        go_to(s);
        step(logic'(xv), 1'b0, xv ? "R3 edge" : "R2 edge");
      end
    end
    // Clear taken from state D with x high.
    go_to(3);
    step(1'b1, 1'b1, "R1 clr from D");
    // Seeded random run.
    for (int i = 0; i < 3000; i++) begin
      logic rx, rr;
      rx = logic'($urandom_range(0, 1));
      rr = ($urandom_range(0, 39) == 0);
      step(rx, rr, rr ? "R1 rnd" : (rx ? "R3 rnd" : "R2 rnd"));
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule